// File: doc/BRIEF.md
# PTP Fine-Adjust System Time Counter

This block keeps a precision-time system clock. The clock has a seconds field and a sub-seconds field. It offers two ways to advance.

- **Coarse mode:** the sub-seconds field grows by a programmed increment on every clock.
- **Fine mode:** a 32-bit addend is summed into a 32-bit frequency accumulator each cycle. The time moves by the increment only in cycles where that sum carries out. Software can therefore trim the effective tick rate in steps of 2^-32 of the clock frequency.

The sub-seconds field wraps at either a binary or a decimal limit. The seconds field steps on that wrap.

Software loads a start time through a pair of initial-value registers and a load strobe. The load is atomic and also empties the accumulator. Software also programs a 64-bit target time. The first time the system time is equal to or later than the target, a sticky hit flag is set. When enabled, that flag drives an interrupt line. After a hit, the flag cannot be set again until the target is rewritten.

Access is a plain word-wide write port and a combinational read port.

Top module: `ptp_fine_clock`

## Requirements
- R1: After reset, every register reads zero, the system time is 0 s / 0 sub-s, the status flag is clear and `irq` is low.
- R2: In fine mode (control bit0 = 1), the accumulator adds the addend modulo 2^32 on every clock edge.
- R3: In fine mode, the sub-seconds field advances by the increment only on an edge where the accumulator sum carries past bit 31. On all other edges the time holds.
- R4: A write to the addend register is first used on the edge after the write edge, and it leaves the accumulator contents untouched.
- R5: In coarse mode (control bit0 = 0), the sub-seconds field advances by the increment on every edge and the accumulator holds its value.
- R6: With binary rollover (control bit3 = 0), a sub-seconds sum of 2^31 or more wraps by subtracting 2^31, and the seconds field increments on the same edge.
- R7: With decimal rollover (control bit3 = 1), the wrap limit is 1,000,000,000 instead of 2^31, and the seconds field still steps on the same edge.
- R8: Writing control with bit2 = 1 loads the initial seconds and sub-seconds into the time on that write edge and clears the accumulator. Bit2 is a strobe and is not stored.
- R9: The status flag (status bit0) sets on the edge after the first cycle in which {seconds, sub-seconds} is greater than or equal to {target seconds, target sub-seconds}. This includes exact equality and a jump past the target.
- R10: The status flag stays set until a write of 1 to status bit0. It is armed only by a write to either target register, so reset does not arm it, and it does not fire again until a target register is rewritten.
- R11: `irq` is high exactly when the status flag is set and control bit1 (interrupt enable) is 1.
- R12: Register addresses are as follows. Reads are combinational from `rd_addr`.

  | Address | Register |
  |---|---|
  | 0 | control |
  | 1 | status |
  | 2 | addend |
  | 3 | increment (8 bits) |
  | 4 | initial seconds |
  | 5 | initial sub-seconds |
  | 6 | target seconds |
  | 7 | target sub-seconds |
  | 8 | current seconds (read-only) |
  | 9 | current sub-seconds (read-only) |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every edge is one accumulator step |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Register read data, combinational |
| irq | output | 1 | Target-time interrupt |

## Verification
Two cases are hard to reach from the ports: the exact-equality target crossing, and the carry phase of the accumulator. The system time never stands still in normal use, and the accumulator is invisible.

The stimulus handles the accumulator by choosing addends that are multiples of 2^30. This places carries on known edges. A write that would reset or advance the accumulator early therefore shows up as a time step one edge early or late.

For the target, the time is first frozen with a zero increment and placed just below the target through the load strobe. A known increment then steps the time onto the target exactly. The bench also jumps past the target, and rewrites the same target value to show that re-arming alone triggers a new hit.

// File: rtl/ptp_clk_pkg.sv
// Package: shared constants for the fine-adjust system time counter.
// Holds the register address map, control bit positions and the
// bus data width. Assumes a 32-bit register data path.
package ptp_clk_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] RA_CTRL     = 4'd0;
    localparam logic [ADDR_W-1:0] RA_STATUS   = 4'd1;
    localparam logic [ADDR_W-1:0] RA_ADDEND   = 4'd2;
    localparam logic [ADDR_W-1:0] RA_INCR     = 4'd3;
    localparam logic [ADDR_W-1:0] RA_INIT_SEC = 4'd4;
    localparam logic [ADDR_W-1:0] RA_INIT_SUB = 4'd5;
    localparam logic [ADDR_W-1:0] RA_TGT_SEC  = 4'd6;
    localparam logic [ADDR_W-1:0] RA_TGT_SUB  = 4'd7;
    localparam logic [ADDR_W-1:0] RA_NOW_SEC  = 4'd8;
    localparam logic [ADDR_W-1:0] RA_NOW_SUB  = 4'd9;

    localparam int CB_FINE  = 0;
    localparam int CB_IRQEN = 1;
    localparam int CB_LOAD  = 2;
    localparam int CB_DEC   = 3;

    typedef struct packed {
        logic dec_roll;
        logic irq_en;
        logic fine;
    } ctrl_t;
endpackage

// File: rtl/ptp_regs.sv
// Module: ptp_regs
// Software-visible register file. Stores control, addend, increment,
// initial time and target time, and turns writes into single-cycle
// strobes (load, target rewrite, status clear).
// Assumes SEC_W, SUB_W, INC_W and ACC_W are all at most DATA_W.
module ptp_regs
    import ptp_clk_pkg::*;
#(
    parameter int SEC_W = 32,
    parameter int SUB_W = 31,
    parameter int INC_W = 8,
    parameter int ACC_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output ctrl_t             ctrl,
    output logic              load_stb,
    output logic              tgt_wr,
    output logic              stat_clr,
    output logic [ACC_W-1:0]  addend,
    output logic [INC_W-1:0]  incr,
    output logic [SEC_W-1:0]  init_sec,
    output logic [SUB_W-1:0]  init_sub,
    output logic [SEC_W-1:0]  tgt_sec,
    output logic [SUB_W-1:0]  tgt_sub
);
    logic hit_ctrl, hit_tsec, hit_tsub;

    // Address decode for the strobes and the written registers
    always_comb begin
        hit_ctrl = wr_en && (wr_addr == RA_CTRL);
        hit_tsec = wr_en && (wr_addr == RA_TGT_SEC);
        hit_tsub = wr_en && (wr_addr == RA_TGT_SUB);
        load_stb = hit_ctrl && wr_data[CB_LOAD];
        tgt_wr   = hit_tsec || hit_tsub;
        stat_clr = wr_en && (wr_addr == RA_STATUS) && wr_data[0];
    end

    // Control register: mode, interrupt enable and rollover select
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (hit_ctrl) begin
            ctrl.fine     <= wr_data[CB_FINE];
            ctrl.irq_en   <= wr_data[CB_IRQEN];
            ctrl.dec_roll <= wr_data[CB_DEC];
        end
    end

    // Rate registers: addend and sub-second increment
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addend <= '0;
            incr   <= '0;
        end else if (wr_en) begin
            if (wr_addr == RA_ADDEND) addend <= wr_data[ACC_W-1:0];
            if (wr_addr == RA_INCR)   incr   <= wr_data[INC_W-1:0];
        end
    end

    // Initial-time registers, consumed only by the load strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_sec <= '0;
            init_sub <= '0;
        end else if (wr_en) begin
            if (wr_addr == RA_INIT_SEC) init_sec <= wr_data[SEC_W-1:0];
            if (wr_addr == RA_INIT_SUB) init_sub <= wr_data[SUB_W-1:0];
        end
    end

    // Target-time registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_sec <= '0;
            tgt_sub <= '0;
        end else begin
            if (hit_tsec) tgt_sec <= wr_data[SEC_W-1:0];
            if (hit_tsub) tgt_sub <= wr_data[SUB_W-1:0];
        end
    end
endmodule

// File: rtl/ptp_accum.sv
// Module: ptp_accum
// Frequency accumulator for fine mode. Adds the addend every cycle and
// reports the carry-out as a time step request. Holds in coarse mode
// and clears on the load strobe (the load wins over a carry).
module ptp_accum #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fine,
    input  logic             clear,
    input  logic [ACC_W-1:0] addend,
    output logic [ACC_W-1:0] acc,
    output logic             carry
);
    logic [ACC_W:0] sum;

    // Wide sum; its top bit is the carry-out
    always_comb begin
        sum   = {1'b0, acc} + {1'b0, addend};
        carry = fine && !clear && sum[ACC_W];
    end

    // Accumulator state: clear on load, add in fine mode, else hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (clear) begin
            acc <= '0;
        end else if (fine) begin
            acc <= sum[ACC_W-1:0];
        end
    end
endmodule

// File: rtl/ptp_time.sv
// Module: ptp_time
// Seconds / sub-seconds counter. On a step request it adds the
// increment to the sub-seconds field, wrapping at 2^SUB_W or at
// DEC_LIMIT and carrying into the seconds field on the same edge.
// The load strobe replaces both fields atomically.
// Assumes DEC_LIMIT < 2^SUB_W and that loaded values lie below the limit.
module ptp_time #(
    parameter int SEC_W     = 32,
    parameter int SUB_W     = 31,
    parameter int INC_W     = 8,
    parameter int DEC_LIMIT = 1_000_000_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             dec_roll,
    input  logic [INC_W-1:0] incr,
    input  logic             load,
    input  logic [SEC_W-1:0] init_sec,
    input  logic [SUB_W-1:0] init_sub,
    output logic [SEC_W-1:0] sec,
    output logic [SUB_W-1:0] sub
);
    localparam logic [SUB_W:0] LIM_BIN = {1'b1, {SUB_W{1'b0}}};
    localparam logic [SUB_W:0] LIM_DEC = (SUB_W+1)'(DEC_LIMIT);

    logic [SUB_W:0] nxt;
    logic [SUB_W:0] lim;
    logic           wrap;

    // Next sub-second value and rollover test
    always_comb begin
        lim  = dec_roll ? LIM_DEC : LIM_BIN;
        nxt  = {1'b0, sub} + (SUB_W+1)'(incr);
        wrap = (nxt >= lim);
    end

    // Time state: load, step with rollover, or hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec <= '0;
            sub <= '0;
        end else if (load) begin
            sec <= init_sec;
            sub <= init_sub;
        end else if (step) begin
            if (wrap) begin
                sub <= SUB_W'(nxt - lim);
                sec <= sec + 1'b1;
            end else begin
                sub <= nxt[SUB_W-1:0];
            end
        end
    end
endmodule

// File: rtl/ptp_target.sv
// Module: ptp_target
// Target-time comparator with a sticky hit flag. A write to either
// target word arms it. The first cycle in which time >= target while
// armed sets the flag and disarms. The flag stays set until cleared,
// and a set on the same edge as a clear wins.
module ptp_target #(
    parameter int SEC_W = 32,
    parameter int SUB_W = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEC_W-1:0] sec,
    input  logic [SUB_W-1:0] sub,
    input  logic [SEC_W-1:0] tgt_sec,
    input  logic [SUB_W-1:0] tgt_sub,
    input  logic             tgt_wr,
    input  logic             stat_clr,
    output logic             reached,
    output logic             armed,
    output logic             hit
);
    logic fire;

    // Greater-or-equal compare on the full time value
    always_comb begin
        reached = ({sec, sub} >= {tgt_sec, tgt_sub});
        fire    = armed && reached;
    end

    // Arming: set by a target rewrite, dropped after one hit
    always_ff @(posedge clk) begin
        if (!rst_n)      armed <= 1'b0;
        else if (tgt_wr) armed <= 1'b1;
        else if (fire)   armed <= 1'b0;
    end

    // Sticky hit flag with software clear
    always_ff @(posedge clk) begin
        if (!rst_n)        hit <= 1'b0;
        else if (fire)     hit <= 1'b1;
        else if (stat_clr) hit <= 1'b0;
    end
endmodule

// File: rtl/ptp_fine_clock.sv
// Module: ptp_fine_clock (top)
// System time counter with fine frequency trimming and a target-time
// interrupt. Ties together the register file, the accumulator, the
// time counter and the target comparator, and drives the read mux.
// Assumes a single clock and synchronous active-low reset.
module ptp_fine_clock
    import ptp_clk_pkg::*;
#(
    parameter int SEC_W     = 32,
    parameter int SUB_W     = 31,
    parameter int INC_W     = 8,
    parameter int ACC_W     = 32,
    parameter int DEC_LIMIT = 1_000_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    ctrl_t            ctrl;
    logic             load_stb, tgt_wr, stat_clr;
    logic [ACC_W-1:0] addend, acc;
    logic [INC_W-1:0] incr;
    logic [SEC_W-1:0] init_sec, tgt_sec, sec;
    logic [SUB_W-1:0] init_sub, tgt_sub, sub;
    logic             carry, step, reached, armed, hit;

    ptp_regs #(.SEC_W(SEC_W), .SUB_W(SUB_W), .INC_W(INC_W), .ACC_W(ACC_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ctrl(ctrl), .load_stb(load_stb), .tgt_wr(tgt_wr), .stat_clr(stat_clr),
        .addend(addend), .incr(incr), .init_sec(init_sec), .init_sub(init_sub),
        .tgt_sec(tgt_sec), .tgt_sub(tgt_sub)
    );

    ptp_accum #(.ACC_W(ACC_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .fine(ctrl.fine), .clear(load_stb),
        .addend(addend), .acc(acc), .carry(carry)
    );

    // Step request: accumulator carry in fine mode, every cycle in coarse mode
    always_comb step = ctrl.fine ? carry : 1'b1;

    ptp_time #(.SEC_W(SEC_W), .SUB_W(SUB_W), .INC_W(INC_W), .DEC_LIMIT(DEC_LIMIT)) u_time (
        .clk(clk), .rst_n(rst_n), .step(step), .dec_roll(ctrl.dec_roll), .incr(incr),
        .load(load_stb), .init_sec(init_sec), .init_sub(init_sub), .sec(sec), .sub(sub)
    );

    ptp_target #(.SEC_W(SEC_W), .SUB_W(SUB_W)) u_tgt (
        .clk(clk), .rst_n(rst_n), .sec(sec), .sub(sub), .tgt_sec(tgt_sec),
        .tgt_sub(tgt_sub), .tgt_wr(tgt_wr), .stat_clr(stat_clr),
        .reached(reached), .armed(armed), .hit(hit)
    );

    // Interrupt gate
    always_comb irq = hit && ctrl.irq_en;

    // Read mux, zero-extending each field to the bus width
    always_comb begin
        case (rd_addr)
            RA_CTRL:     rd_data = DATA_W'({ctrl.dec_roll, 1'b0, ctrl.irq_en, ctrl.fine});
            RA_STATUS:   rd_data = DATA_W'(hit);
            RA_ADDEND:   rd_data = DATA_W'(addend);
            RA_INCR:     rd_data = DATA_W'(incr);
            RA_INIT_SEC: rd_data = DATA_W'(init_sec);
            RA_INIT_SUB: rd_data = DATA_W'(init_sub);
            RA_TGT_SEC:  rd_data = DATA_W'(tgt_sec);
            RA_TGT_SUB:  rd_data = DATA_W'(tgt_sub);
            RA_NOW_SEC:  rd_data = DATA_W'(sec);
            RA_NOW_SUB:  rd_data = DATA_W'(sub);
            default:     rd_data = '0;
        endcase
    end
endmodule

// File: rtl/ptp_fine_clock_chk.sv
// Module: ptp_fine_clock_chk
// Assertion checker bound to ptp_fine_clock. It observes the internal
// step, accumulator and target signals.
module ptp_fine_clock_chk #(
    parameter int SEC_W = 32,
    parameter int SUB_W = 31,
    parameter int ACC_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fine,
    input logic             irq_en,
    input logic             load,
    input logic             carry,
    input logic [ACC_W-1:0] acc,
    input logic [ACC_W-1:0] addend,
    input logic [SEC_W-1:0] sec,
    input logic [SUB_W-1:0] sub,
    input logic             tgt_wr,
    input logic             stat_clr,
    input logic             reached,
    input logic             armed,
    input logic             hit,
    input logic             irq
);
    assert_acc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fine && !load) |=> acc == ACC_W'($past(acc) + $past(addend)));

    assert_no_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fine && !carry && !load) |=> ($stable(sec) && $stable(sub)));

    assert_acc_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!fine && !load) |=> $stable(acc));

    assert_sec_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (sec == $past(sec) || sec == $past(sec) + 1'b1));

    assert_load_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> acc == '0);

    assert_hit_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hit) |-> ($past(armed) && $past(reached)));

    assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !stat_clr) |=> hit);

    assert_no_rearm_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !tgt_wr) |=> !armed);

    assert_irq_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);
endmodule

bind ptp_fine_clock ptp_fine_clock_chk #(.SEC_W(SEC_W), .SUB_W(SUB_W), .ACC_W(ACC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .fine(ctrl.fine), .irq_en(ctrl.irq_en), .load(load_stb),
    .carry(carry), .acc(acc), .addend(addend), .sec(sec), .sub(sub), .tgt_wr(tgt_wr),
    .stat_clr(stat_clr), .reached(reached), .armed(armed), .hit(hit), .irq(irq)
);

// File: tb/sim_ptp_fine_clock.sv
`timescale 1ns/1ps
module sim_ptp_fine_clock;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq;
    int          errors = 0;
    int          checks = 0;
    bit          done = 1'b0;

    ptp_fine_clock u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        rd_addr = a;
        #0.4;
        d = rd_data;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        for (int a = 0; a < 10; a++) begin
            rd(4'(a), v);
            chk($sformatf("R1 reg %0d after reset", a), v, 32'h0);
        end
        chk("R1 irq after reset", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_fine;
        logic [31:0] v;
        wr(4'd0, 32'h1);             // fine mode, addend still 0
        wr(4'd3, 32'd8);
        wr(4'd0, 32'h5);             // load zero time, clear accumulator
        wr(4'd2, 32'h4000_0000);     // addend used from the next edge
        idle(3);
        rd(4'd9, v); chk("R3 no carry yet", v, 32'd0);
        idle(1);
        rd(4'd9, v); chk("R2 R3 first carry", v, 32'd8);
        idle(4);
        rd(4'd9, v); chk("R2 second carry", v, 32'd16);
        idle(1);                     // accumulator now 2^30
        wr(4'd2, 32'hC000_0000);
        rd(4'd9, v); chk("R4 new addend not used on write edge", v, 32'd16);
        idle(1);
        rd(4'd9, v); chk("R4 accumulator kept across addend write", v, 32'd24);
        rd(4'd2, v); chk("R12 addend readback", v, 32'hC000_0000);
    endtask

    task automatic t_coarse;
        logic [31:0] v;
        wr(4'd0, 32'h0);
        wr(4'd4, 32'd0);
        wr(4'd5, 32'd0);
        wr(4'd0, 32'h4);
        rd(4'd9, v); chk("R8 load in coarse", v, 32'd0);
        idle(5);
        rd(4'd9, v); chk("R5 coarse step each edge", v, 32'd40);
    endtask

    task automatic t_bin_roll;
        logic [31:0] s, u;
        wr(4'd4, 32'd5);
        wr(4'd5, 32'h7FFF_FFEC);
        wr(4'd0, 32'h4);
        rd(4'd8, s); rd(4'd9, u);
        chk("R8 loaded seconds", s, 32'd5);
        chk("R8 loaded sub-seconds", u, 32'h7FFF_FFEC);
        idle(2);
        rd(4'd8, s); rd(4'd9, u);
        chk("R6 before wrap sec", s, 32'd5);
        chk("R6 before wrap sub", u, 32'h7FFF_FFFC);
        idle(1);
        rd(4'd8, s); rd(4'd9, u);
        chk("R6 wrap sec", s, 32'd6);
        chk("R6 wrap sub", u, 32'd4);
    endtask

    task automatic t_dec_roll;
        logic [31:0] s, u;
        wr(4'd4, 32'd7);
        wr(4'd5, 32'd999_999_990);
        wr(4'd0, 32'hC);             // decimal rollover plus load
        idle(1);
        rd(4'd9, u); chk("R7 before decimal wrap", u, 32'd999_999_998);
        idle(1);
        rd(4'd8, s); rd(4'd9, u);
        chk("R7 decimal wrap sec", s, 32'd8);
        chk("R7 decimal wrap sub", u, 32'd6);
    endtask

    task automatic t_load_fine;
        logic [31:0] s, u;
        wr(4'd0, 32'h1);
        wr(4'd2, 32'h8000_0000);
        idle(1);
        wr(4'd4, 32'd100);
        wr(4'd5, 32'd1000);
        wr(4'd0, 32'h5);
        rd(4'd8, s); rd(4'd9, u);
        chk("R8 fine load sec", s, 32'd100);
        chk("R8 fine load sub", u, 32'd1000);
        rd(4'd0, s); chk("R8 load bit not stored", s, 32'h1);
        idle(1);
        rd(4'd9, u); chk("R8 accumulator cleared: no carry", u, 32'd1000);
        idle(1);
        rd(4'd9, u); chk("R8 accumulator cleared: carry", u, 32'd1008);
    endtask

    task automatic t_target;
        logic [31:0] v;
        wr(4'd3, 32'd0);
        wr(4'd0, 32'h2);
        wr(4'd4, 32'd20);
        wr(4'd5, 32'd0);
        wr(4'd0, 32'h6);
        idle(2);
        rd(4'd1, v); chk("R10 reset does not arm", v, 32'd0);
        wr(4'd6, 32'd21);
        wr(4'd7, 32'd100);
        idle(2);
        rd(4'd1, v); chk("R9 below target", v, 32'd0);
        chk("R11 irq low below target", {31'b0, irq}, 32'd0);
        wr(4'd4, 32'd21);
        wr(4'd5, 32'd5000);
        wr(4'd0, 32'h6);
        rd(4'd1, v); chk("R9 flag one edge after reaching", v, 32'd0);
        idle(1);
        rd(4'd1, v); chk("R9 jump past target", v, 32'd1);
        chk("R11 irq high", {31'b0, irq}, 32'd1);
        wr(4'd1, 32'd1);
        idle(3);
        rd(4'd1, v); chk("R10 no refire after clear", v, 32'd0);
        chk("R11 irq low after clear", {31'b0, irq}, 32'd0);
        wr(4'd7, 32'd100);
        idle(1);
        rd(4'd1, v); chk("R10 rearm by rewrite", v, 32'd1);
        idle(2);
        rd(4'd1, v); chk("R10 sticky", v, 32'd1);
        wr(4'd0, 32'h0);
        chk("R11 irq masked", {31'b0, irq}, 32'd0);
        wr(4'd0, 32'h2);
        chk("R11 irq unmasked", {31'b0, irq}, 32'd1);
        wr(4'd1, 32'd1);
        wr(4'd6, 32'd30);
        wr(4'd7, 32'd48);
        wr(4'd3, 32'd16);
        wr(4'd4, 32'd30);
        wr(4'd5, 32'd0);
        wr(4'd0, 32'h6);
        idle(3);
        rd(4'd9, v); chk("R9 time on target", v, 32'd48);
        rd(4'd1, v); chk("R9 not yet flagged", v, 32'd0);
        idle(1);
        rd(4'd1, v); chk("R9 exact equality", v, 32'd1);
        rd(4'd6, v); chk("R12 target seconds readback", v, 32'd30);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fine();
        t_coarse();
        t_bin_roll();
        t_dec_roll();
        t_load_fine();
        t_target();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule